// File: doc/BRIEF.md
# Conditional Branch and Call Unit

This block runs the control-transfer instructions of an 8-bit processor that has a 16-bit address space. A start strobe captures the current program counter, stack pointer, the HL register pair and the Zero and Carry flags. The unit then reads the opcode at that program counter over a byte-wide memory port. It decodes the opcode against a fixed map of absolute, relative, register-indirect, call and return transfers. For opcodes that carry an immediate, it reads one or two operand bytes. It evaluates the condition against the captured flags. When a call or return is taken, it exchanges a 16-bit return address with an external stack engine.

The unit finishes with a one-cycle `done` pulse. While `done` is high, `next_pc`, `next_sp`, `cycles` and `illegal` are valid. The cycle count is in machine clock cycles and depends on whether the branch was taken. An opcode outside the supported set raises `illegal` and leaves both PC and SP unchanged. The surrounding processor writes the returned values back into its own register file.

States:
- `S_IDLE` waits for `start`.
- `S_OPC` fetches the opcode.
- `S_PLAN` decodes the opcode. It goes to `S_DONE` on an illegal opcode, to `S_RESOLVE` for one-byte opcodes, and to `S_IMM_LO` otherwise.
- `S_IMM_LO` and `S_IMM_HI` fetch the operand bytes. `S_IMM_LO` goes on to `S_IMM_HI` for three-byte opcodes and to `S_RESOLVE` otherwise.
- `S_RESOLVE` goes to `S_PUSH` for a taken call, to `S_POP` for a taken return, and to `S_DONE` otherwise.
- `S_PUSH` and `S_POP` wait for the stack acknowledge and then go to `S_DONE`.
- `S_DONE` always returns to `S_IDLE`.

Top module: `flow_ctl_unit`

## Requirements
- R1: Absolute jumps load PC from the immediate and are 3 bytes long. The immediate low byte is at PC+1 and the high byte at PC+2. Opcode 0xC3 costs 16 cycles. Opcodes 0xC2, 0xCA, 0xD2 and 0xDA cost 16 cycles when taken and 12 when not.
- R2: Opcode 0xE9 loads PC from the HL pair, reads no operand and costs 4 cycles.
- R3: Relative jumps are 2 bytes long. The target is the opcode address + 2 + the sign-extended operand byte. Opcode 0x18 costs 12 cycles. Opcodes 0x20, 0x28, 0x30 and 0x38 cost 12 cycles when taken and 8 when not.
- R4: A taken call issues one push request at address SP-2 with data equal to the opcode address + 3, then loads PC from the immediate. The result is next_sp = SP-2 and 24 cycles. Call opcodes are 0xCD (unconditional) and 0xC4, 0xCC, 0xD4, 0xDC (conditional). A not-taken call costs 12 cycles and issues no stack request.
- R5: A taken return issues one pop request at address SP and loads PC from the popped word, with next_sp = SP+2. Opcode 0xC9 costs 16 cycles. Opcodes 0xC0, 0xC8, 0xD0 and 0xD8 cost 20 cycles when taken and 8 when not, and issue no stack request when not taken.
- R6: Opcode bits [4:3] of a conditional form select its condition: 00 = Zero clear, 01 = Zero set, 10 = Carry clear, 11 = Carry set. Unconditional forms ignore both flags.
- R7: When a condition fails, next_pc = PC + instruction length (3, 2 or 1 bytes) and next_sp = SP.
- R8: All PC, target, return-address and stack-address arithmetic wraps modulo 2^16.
- R9: Any other opcode gives illegal = 1, next_pc = PC, next_sp = SP and cycles = 0. It reads only the opcode byte and issues no stack request.
- R10: `done` is high for exactly one cycle per accepted start, and never while a stack request is still waiting for its acknowledge. A start that arrives while the unit is busy, including in the `done` cycle, is ignored.
- R11: During and right after reset, `done`, `mem_req` and `stk_req` are low.
- R12: `mem_req` and `mem_addr` hold steady until `mem_ack`. Memory and stack requests are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction; accepted only when idle |
| pc_in | input | 16 | Address of the opcode |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | HL register pair |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| stk_req | output | 1 | Stack engine request |
| stk_push | output | 1 | 1 = push, 0 = pop |
| stk_addr | output | 16 | Address of the low byte of the stack word |
| stk_wdata | output | 16 | Word to push |
| stk_ack | input | 1 | Stack transaction completes this cycle |
| stk_rdata | input | 16 | Popped word, valid with stk_ack on a pop |
| done | output | 1 | Result valid this cycle |
| next_pc | output | 16 | Program counter after the instruction |
| next_sp | output | 16 | Stack pointer after the instruction |
| cycles | output | 5 | Machine cycles consumed |
| illegal | output | 1 | Opcode outside the supported set |

## Verification
Two events can fall into the same clock edge. First, the stack acknowledge can arrive in the same cycle as the request, so the unit leaves `S_PUSH` or `S_POP` at once and the `done` cycle follows immediately. Second, a new `start` can land in the `done` cycle itself. The bench provokes the first by running the vector table with zero-latency memory and stack responders on every third entry. It provokes the second by raising `start` on the very edge that samples `done`. It then judges the run by `mem_req` staying low and by no second `done` pulse appearing over the following cycles.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        K_JP, K_JR, K_JPHL, K_CALL, K_RET, K_BAD
    } kind_t;

    typedef enum logic [2:0] {
        C_ALW, C_NZ, C_Z, C_NC, C_C
    } cond_t;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_PLAN, S_IMM_LO, S_IMM_HI,
        S_RESOLVE, S_PUSH, S_POP, S_DONE
    } st_t;

    localparam int COST_JP_HIT    = 16;
    localparam int COST_JP_MISS   = 12;
    localparam int COST_JPHL      = 4;
    localparam int COST_JR_HIT    = 12;
    localparam int COST_JR_MISS   = 8;
    localparam int COST_CALL_HIT  = 24;
    localparam int COST_CALL_MISS = 12;
    localparam int COST_RET_ALW   = 16;
    localparam int COST_RET_HIT   = 20;
    localparam int COST_RET_MISS  = 8;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [7:0]    op,
    output kind_t         kind,
    output cond_t         cond,
    output logic [1:0]    len,
    output logic [CW-1:0] cyc_hit,
    output logic [CW-1:0] cyc_miss
);
    cond_t field_cond;

    // Condition selector carried in opcode bits [4:3]
    always_comb begin
        case (op[4:3])
            2'b00:   field_cond = C_NZ;
            2'b01:   field_cond = C_Z;
            2'b10:   field_cond = C_NC;
            default: field_cond = C_C;
        endcase
    end

    always_comb begin
        kind     = K_BAD;
        cond     = C_ALW;
        len      = 2'd1;
        cyc_hit  = '0;
        cyc_miss = '0;
        case (op)
            8'hC3: begin
                kind = K_JP; len = 2'd3;
                cyc_hit = CW'(COST_JP_HIT); cyc_miss = CW'(COST_JP_HIT);
            end
            8'hC2, 8'hCA, 8'hD2, 8'hDA: begin
                kind = K_JP; cond = field_cond; len = 2'd3;
                cyc_hit = CW'(COST_JP_HIT); cyc_miss = CW'(COST_JP_MISS);
            end
            8'hE9: begin
                kind = K_JPHL; len = 2'd1;
                cyc_hit = CW'(COST_JPHL); cyc_miss = CW'(COST_JPHL);
            end
            8'h18: begin
                kind = K_JR; len = 2'd2;
                cyc_hit = CW'(COST_JR_HIT); cyc_miss = CW'(COST_JR_HIT);
            end
            8'h20, 8'h28, 8'h30, 8'h38: begin
                kind = K_JR; cond = field_cond; len = 2'd2;
                cyc_hit = CW'(COST_JR_HIT); cyc_miss = CW'(COST_JR_MISS);
            end
            8'hCD: begin
                kind = K_CALL; len = 2'd3;
                cyc_hit = CW'(COST_CALL_HIT); cyc_miss = CW'(COST_CALL_HIT);
            end
            8'hC4, 8'hCC, 8'hD4, 8'hDC: begin
                kind = K_CALL; cond = field_cond; len = 2'd3;
                cyc_hit = CW'(COST_CALL_HIT); cyc_miss = CW'(COST_CALL_MISS);
            end
            8'hC9: begin
                kind = K_RET; len = 2'd1;
                cyc_hit = CW'(COST_RET_ALW); cyc_miss = CW'(COST_RET_ALW);
            end
            8'hC0, 8'hC8, 8'hD0, 8'hD8: begin
                kind = K_RET; cond = field_cond; len = 2'd1;
                cyc_hit = CW'(COST_RET_HIT); cyc_miss = CW'(COST_RET_MISS);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
(
    input  cond_t cond,
    input  logic  z,
    input  logic  c,
    output logic  hit
);
    always_comb begin
        unique case (cond)
            C_ALW:   hit = 1'b1;
            C_NZ:    hit = ~z;
            C_Z:     hit = z;
            C_NC:    hit = ~c;
            C_C:     hit = c;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/flow_target.sv
module flow_target
    import flow_pkg::*;
#(
    parameter int AW = 16
) (
    input  kind_t         kind,
    input  logic [1:0]    len,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] hl,
    input  logic [15:0]   imm,
    output logic [AW-1:0] taken_pc,
    output logic [AW-1:0] fall_pc,
    output logic [AW-1:0] ret_addr
);
    localparam int EXT_W = AW - 8;

    logic [AW-1:0] rel_off;
    logic [AW-1:0] abs_tgt;

    assign rel_off  = {{EXT_W{imm[7]}}, imm[7:0]};
    assign abs_tgt  = AW'(imm);
    assign fall_pc  = pc + AW'(len);
    assign ret_addr = pc + AW'(3);

    always_comb begin
        if (kind == K_JP || kind == K_CALL)
            taken_pc = abs_tgt;
        else if (kind == K_JR)
            taken_pc = pc + AW'(2) + rel_off;
        else if (kind == K_JPHL)
            taken_pc = hl;
        else
            taken_pc = fall_pc;
    end
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
    import flow_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] hl_in,
    input  logic          flag_z,
    input  logic          flag_c,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          stk_req,
    output logic          stk_push,
    output logic [AW-1:0] stk_addr,
    output logic [15:0]   stk_wdata,
    input  logic          stk_ack,
    input  logic [15:0]   stk_rdata,
    output logic          done,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] next_sp,
    output logic [CW-1:0] cycles,
    output logic          illegal
);
    localparam logic [AW-1:0] STEP2 = AW'(2);

    st_t           state, state_nx;
    logic [AW-1:0] pc_q, sp_q, hl_q, pop_q;
    logic [7:0]    op_q, lo_q, hi_q;
    logic          z_q, c_q;

    kind_t         kind;
    cond_t         cond;
    logic [1:0]    len;
    logic [CW-1:0] cyc_hit, cyc_miss;
    logic          hit;
    logic [AW-1:0] taken_pc, fall_pc, ret_addr;

    flow_decode #(.CW(CW)) u_dec (
        .op(op_q), .kind(kind), .cond(cond), .len(len),
        .cyc_hit(cyc_hit), .cyc_miss(cyc_miss)
    );

    flow_cond u_cond (.cond(cond), .z(z_q), .c(c_q), .hit(hit));

    flow_target #(.AW(AW)) u_tgt (
        .kind(kind), .len(len), .pc(pc_q), .hl(hl_q), .imm({hi_q, lo_q}),
        .taken_pc(taken_pc), .fall_pc(fall_pc), .ret_addr(ret_addr)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_OPC;
            S_OPC:     if (mem_ack) state_nx = S_PLAN;
            S_PLAN: begin
                if (kind == K_BAD)    state_nx = S_DONE;
                else if (len == 2'd1) state_nx = S_RESOLVE;
                else                  state_nx = S_IMM_LO;
            end
            S_IMM_LO:  if (mem_ack) state_nx = (len == 2'd3) ? S_IMM_HI : S_RESOLVE;
            S_IMM_HI:  if (mem_ack) state_nx = S_RESOLVE;
            S_RESOLVE: begin
                if (hit && kind == K_CALL)     state_nx = S_PUSH;
                else if (hit && kind == K_RET) state_nx = S_POP;
                else                           state_nx = S_DONE;
            end
            S_PUSH:    if (stk_ack) state_nx = S_DONE;
            S_POP:     if (stk_ack) state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State register and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pc_q  <= '0; sp_q <= '0; hl_q <= '0; pop_q <= '0;
            op_q  <= '0; lo_q <= '0; hi_q <= '0;
            z_q   <= 1'b0; c_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                pc_q <= pc_in; sp_q <= sp_in; hl_q <= hl_in;
                z_q  <= flag_z; c_q <= flag_c;
                lo_q <= '0; hi_q <= '0;
            end
            if (state == S_OPC && mem_ack)    op_q  <= mem_rdata;
            if (state == S_IMM_LO && mem_ack) lo_q  <= mem_rdata;
            if (state == S_IMM_HI && mem_ack) hi_q  <= mem_rdata;
            if (state == S_POP && stk_ack)    pop_q <= AW'(stk_rdata);
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = pc_q;
        unique case (state)
            S_OPC:    mem_req = 1'b1;
            S_IMM_LO: begin mem_req = 1'b1; mem_addr = pc_q + AW'(1); end
            S_IMM_HI: begin mem_req = 1'b1; mem_addr = pc_q + STEP2;  end
            default:  ;
        endcase
        stk_req   = (state == S_PUSH) || (state == S_POP);
        stk_push  = (state == S_PUSH);
        stk_addr  = stk_push ? (sp_q - STEP2) : sp_q;
        stk_wdata = 16'(ret_addr);

        done    = (state == S_DONE);
        illegal = (kind == K_BAD);
        if (illegal) begin
            next_pc = pc_q;
            next_sp = sp_q;
            cycles  = '0;
        end else if (!hit) begin
            next_pc = fall_pc;
            next_sp = sp_q;
            cycles  = cyc_miss;
        end else begin
            next_pc = (kind == K_RET) ? pop_q : taken_pc;
            if (kind == K_CALL)     next_sp = sp_q - STEP2;
            else if (kind == K_RET) next_sp = sp_q + STEP2;
            else                    next_sp = sp_q;
            cycles = cyc_hit;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_AFTER_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_req && !stk_ack) |=> !done); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12

    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && stk_req)); // R12

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (next_sp == sp_q || next_sp == sp_q - STEP2 || next_sp == sp_q + STEP2)); // R4

    AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_req && stk_push) |-> (stk_wdata == 16'(pc_q + AW'(3)))); // R4

endmodule

// File: tb/sim_flow_ctl_unit.sv
module sim_flow_ctl_unit;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [15:0] hl;
        logic        z;
        logic        c;
        logic [15:0] pop;
        logic [15:0] epc;
        logic [15:0] esp;
        logic [7:0]  ecyc;
        logic        eill;
        logic [1:0]  estk;   // 0 none, 1 push, 2 pop
        logic [1:0]  erd;    // memory reads expected
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        // R1 absolute, R6 conditions
        '{8'hC3,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b0,1'b0,16'h0,16'h1234,16'hFFFE,8'd16,1'b0,2'd0,2'd3},
        '{8'hC2,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h1234,16'hFFFE,8'd16,1'b0,2'd0,2'd3},
        '{8'hC2,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1003,16'hFFFE,8'd12,1'b0,2'd0,2'd3},
        '{8'hCA,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1234,16'hFFFE,8'd16,1'b0,2'd0,2'd3},
        '{8'hCA,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h1003,16'hFFFE,8'd12,1'b0,2'd0,2'd3},
        '{8'hD2,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1234,16'hFFFE,8'd16,1'b0,2'd0,2'd3},
        '{8'hD2,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h1003,16'hFFFE,8'd12,1'b0,2'd0,2'd3},
        '{8'hDA,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h1234,16'hFFFE,8'd16,1'b0,2'd0,2'd3},
        '{8'hDA,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1003,16'hFFFE,8'd12,1'b0,2'd0,2'd3},
        // R2 register indirect
        '{8'hE9,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b1,1'b1,16'h0,16'hC050,16'hFFFE,8'd4,1'b0,2'd0,2'd1},
        // R3 relative
        '{8'h18,8'h05,8'h00,16'h1000,16'hFFFE,16'hC050,1'b1,1'b1,16'h0,16'h1007,16'hFFFE,8'd12,1'b0,2'd0,2'd2},
        '{8'h18,8'hFE,8'h00,16'h1000,16'hFFFE,16'hC050,1'b0,1'b0,16'h0,16'h1000,16'hFFFE,8'd12,1'b0,2'd0,2'd2},
        '{8'h20,8'h80,8'h00,16'h1000,16'hFFFE,16'hC050,1'b0,1'b0,16'h0,16'h0F82,16'hFFFE,8'd12,1'b0,2'd0,2'd2},
        '{8'h20,8'h80,8'h00,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1002,16'hFFFE,8'd8,1'b0,2'd0,2'd2},
        '{8'h28,8'h10,8'h00,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1012,16'hFFFE,8'd12,1'b0,2'd0,2'd2},
        '{8'h30,8'h7F,8'h00,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1081,16'hFFFE,8'd12,1'b0,2'd0,2'd2},
        '{8'h38,8'h7F,8'h00,16'h1000,16'hFFFE,16'hC050,1'b1,1'b0,16'h0,16'h1002,16'hFFFE,8'd8,1'b0,2'd0,2'd2},
        // R4 calls
        '{8'hCD,8'h00,8'h40,16'h1000,16'hFFFE,16'hC050,1'b1,1'b1,16'h0,16'h4000,16'hFFFC,8'd24,1'b0,2'd1,2'd3},
        '{8'hC4,8'h00,8'h40,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h4000,16'hFFFC,8'd24,1'b0,2'd1,2'd3},
        '{8'hCC,8'h00,8'h40,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h1003,16'hFFFE,8'd12,1'b0,2'd0,2'd3},
        '{8'hD4,8'h00,8'h40,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h1003,16'hFFFE,8'd12,1'b0,2'd0,2'd3},
        '{8'hDC,8'h00,8'h40,16'h1000,16'hFFFE,16'hC050,1'b0,1'b1,16'h0,16'h4000,16'hFFFC,8'd24,1'b0,2'd1,2'd3},
        // R5 returns
        '{8'hC9,8'h00,8'h00,16'h1000,16'hD000,16'hC050,1'b1,1'b1,16'hABCD,16'hABCD,16'hD002,8'd16,1'b0,2'd2,2'd1},
        '{8'hC0,8'h00,8'h00,16'h1000,16'hD000,16'hC050,1'b1,1'b0,16'hABCD,16'h1001,16'hD000,8'd8,1'b0,2'd0,2'd1},
        '{8'hC8,8'h00,8'h00,16'h1000,16'hD000,16'hC050,1'b1,1'b0,16'hABCD,16'hABCD,16'hD002,8'd20,1'b0,2'd2,2'd1},
        '{8'hD0,8'h00,8'h00,16'h1000,16'hD000,16'hC050,1'b1,1'b0,16'h5A5A,16'h5A5A,16'hD002,8'd20,1'b0,2'd2,2'd1},
        '{8'hD8,8'h00,8'h00,16'h1000,16'hD000,16'hC050,1'b1,1'b0,16'hABCD,16'h1001,16'hD000,8'd8,1'b0,2'd0,2'd1},
        // R9 illegal
        '{8'h00,8'h34,8'h12,16'h1000,16'hFFFE,16'hC050,1'b0,1'b0,16'h0,16'h1000,16'hFFFE,8'd0,1'b1,2'd0,2'd1},
        '{8'hC1,8'h34,8'h12,16'h2468,16'h8000,16'hC050,1'b0,1'b0,16'h0,16'h2468,16'h8000,8'd0,1'b1,2'd0,2'd1},
        // R8 wrap
        '{8'h18,8'h7F,8'h00,16'hFFF0,16'hFFFE,16'hC050,1'b0,1'b0,16'h0,16'h0071,16'hFFFE,8'd12,1'b0,2'd0,2'd2},
        '{8'hCD,8'h00,8'h20,16'hFFFE,16'h0001,16'hC050,1'b0,1'b0,16'h0,16'h2000,16'hFFFF,8'd24,1'b0,2'd1,2'd3},
        '{8'h20,8'h80,8'h00,16'h0000,16'h0000,16'hC050,1'b0,1'b0,16'hFFFF,16'hFF82,16'h0000,8'd12,1'b0,2'd0,2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0;
    logic        mem_req, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        stk_req, stk_push, stk_ack = 1'b0;
    logic [15:0] stk_addr, stk_wdata, stk_rdata = '0;
    logic        done, illegal;
    logic [15:0] next_pc, next_sp;
    logic [4:0]  cycles;

    always #5 clk = ~clk;

    flow_ctl_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in), .sp_in(sp_in),
        .hl_in(hl_in), .flag_z(flag_z), .flag_c(flag_c),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .stk_req(stk_req), .stk_push(stk_push), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .stk_ack(stk_ack), .stk_rdata(stk_rdata),
        .done(done), .next_pc(next_pc), .next_sp(next_sp), .cycles(cycles), .illegal(illegal)
    );

    int n_chk = 0, n_err = 0;
    // responder model state
    logic [15:0] w_pc = '0, w_sp = '0, w_pop = '0;
    logic [7:0]  w_op = '0, w_lo = '0, w_hi = '0;
    int mem_lat = 0, stk_lat = 0, mem_wait = 0, stk_wait = 0;
    int rd_cnt = 0, stk_cnt = 0, done_cnt = 0;
    logic        last_push = 1'b0;
    logic [15:0] last_saddr = '0, last_sdata = '0;

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        logic [15:0] p1, p2;
        p1 = w_pc + 16'd1;
        p2 = w_pc + 16'd2;
        if (a == w_pc)      return w_op;
        else if (a == p1)   return w_lo;
        else if (a == p2)   return w_hi;
        else                return 8'hEE;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory and stack responders, acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (mem_req) begin
                if (mem_wait >= mem_lat) begin
                    mem_ack = 1'b1; mem_rdata = mbyte(mem_addr);
                    rd_cnt++; mem_wait = 0;
                end else begin
                    mem_ack = 1'b0; mem_wait++;
                end
            end else begin
                mem_ack = 1'b0; mem_wait = 0;
            end
            if (stk_req) begin
                if (stk_wait >= stk_lat) begin
                    stk_ack = 1'b1; stk_cnt++; stk_wait = 0;
                    last_push = stk_push; last_saddr = stk_addr; last_sdata = stk_wdata;
                    stk_rdata = (!stk_push && stk_addr == w_sp) ? w_pop : 16'hDEAD;
                end else begin
                    stk_ack = 1'b0; stk_wait++;
                end
            end else begin
                stk_ack = 1'b0; stk_wait = 0;
            end
        end
    end

    task automatic launch(input vec_t v);
        w_pc = v.pc; w_sp = v.sp; w_pop = v.pop;
        w_op = v.op; w_lo = v.lo; w_hi = v.hi;
        rd_cnt = 0; stk_cnt = 0; done_cnt = 0;
        pc_in = v.pc; sp_in = v.sp; hl_in = v.hl; flag_z = v.z; flag_c = v.c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic judge(input vec_t v, input string req);
        chk(next_pc == v.epc, req, "next_pc", next_pc, v.epc);
        chk(next_sp == v.esp, req, "next_sp", next_sp, v.esp);
        chk(8'(cycles) == v.ecyc, req, "cycles", cycles, v.ecyc);
        chk(illegal == v.eill, req, "illegal", illegal, v.eill);
        chk(rd_cnt == int'(v.erd), req, "memory reads", rd_cnt, v.erd);
        chk(stk_cnt == (v.estk != 0 ? 1 : 0), req, "stack requests", stk_cnt, v.estk != 0);
        if (v.estk == 2'd1) begin
            chk(last_push == 1'b1, "R4", "push flag", last_push, 1);
            chk(last_saddr == v.sp - 16'd2, "R4", "push address", last_saddr, v.sp - 16'd2);
            chk(last_sdata == v.pc + 16'd3, "R4", "push data", last_sdata, v.pc + 16'd3);
        end
        if (v.estk == 2'd2) begin
            chk(last_push == 1'b0, "R5", "pop flag", last_push, 0);
            chk(last_saddr == v.sp, "R5", "pop address", last_saddr, v.sp);
        end
    endtask

    function automatic string tag_of(input int i);
        if (i < 9)       return "R1/R6/R7";
        else if (i == 9) return "R2";
        else if (i < 17) return "R3/R6/R7";
        else if (i < 22) return "R4/R6";
        else if (i < 27) return "R5/R6";
        else if (i < 29) return "R9";
        else             return "R8";
    endfunction

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        bit seen;
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !stk_req, "R11", "outputs in reset", {done, mem_req, stk_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_req && !stk_req, "R11", "outputs after reset", {done, mem_req, stk_req}, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            mem_lat = i % 3;
            stk_lat = (i + 1) % 3;
            launch(VECS[i]);
            wait_done(seen);
            chk(seen, tag_of(i), "done seen", seen, 1);
            if (seen) judge(VECS[i], tag_of(i));
            @(negedge clk);
            chk(!done && done_cnt == 1, "R10", "single done pulse", done_cnt, 1);
        end

        // R10: start while busy is ignored
        mem_lat = 3; stk_lat = 2;
        launch(VECS[17]);
        @(negedge clk);
        pc_in = 16'h5555; sp_in = 16'h0100; flag_z = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        chk(seen && next_pc == 16'h4000 && next_sp == 16'hFFFC, "R10", "busy start ignored pc",
            next_pc, 16'h4000);
        @(negedge clk);
        chk(rd_cnt == 3 && done_cnt == 1, "R10", "busy start reads", rd_cnt, 3);

        // R10: start in the done cycle is ignored; R12 stack ack same cycle as request
        mem_lat = 0; stk_lat = 0;
        launch(VECS[22]);
        wait_done(seen);
        chk(seen && next_pc == 16'hABCD, "R5", "zero-latency pop", next_pc, 16'hABCD);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(!mem_req && !stk_req, "R10", "start in done cycle ignored", mem_req, 0);
            @(negedge clk);
        end
        chk(done_cnt == 1, "R10", "no second done", done_cnt, 1);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule